// File: doc/BRIEF.md
# EEPROM Access and Burst Loader

This block gives a host a small register window onto an external byte-wide EEPROM. Through an address register, a data register and a control register the host can fetch one byte from the EEPROM or store one byte into it. The block runs the request, holds the EEPROM port until the device acknowledges, and then clears the request bit by itself. Below the block sits an adapter that drives the physical serial protocol. The block talks to it over a generic byte port with a request/acknowledge handshake.

The block also has a burst mode that copies EEPROM contents into a 24-bit on-chip memory space. The EEPROM stream is a chain of records. Each record holds a two-byte target offset, high byte first, then a one-byte length, then that many payload bytes. A record whose length is zero ends the burst. Each payload byte goes out on a memory write port. Its address joins a host-programmed 9-bit window base, used as the upper bits, to the 15-bit offset from the record. The offset then advances by one. A burst begins at EEPROM address 0 if the EEPROM has not been touched since reset. Otherwise it begins at the address just past the last byte accessed, whether that access was a single access or part of a burst.

Top module: `eeprom_burst_loader`

## Requirements
- R1: After reset the address, data, control and window-base registers read 0, `ee_req` is 0 and `mem_we` is 0.
- R2: Writing the control register (index 2) with bit 1 set reads one byte from the EEPROM at the address register (index 0) into the data register (index 1). Bit 1 reads 1 until the read completes, then clears, and the data register holds the byte once it has cleared.
- R3: Writing the control register with bit 0 set stores data register bits [7:0] at the EEPROM address in the address register. Bit 0 clears by itself once the EEPROM acknowledges.
- R4: Writing the control register with bit 2 set starts a burst, and bit 2 reads 1 until the burst ends. Control bit 3 (busy) reads 1 in every cycle the block is not idle, starting the cycle after the launching write.
- R5: The first EEPROM address fetched by a burst is 0 if no EEPROM access has occurred since reset. Otherwise it is one past the last EEPROM address read or written.
- R6: The burst stream is a sequence of records. Each record is offset high byte, offset low byte, length, then that many payload bytes. A record with length 0 ends the burst and produces no memory write.
- R7: For each payload byte the memory address is the window base register bits [8:0] (index 3) placed above offset bits [14:0]. Offset bit 15 is ignored, and the offset increments by one per byte, wrapping within its 15 bits.
- R8: Each payload byte appears on `mem_wdata` with `mem_we` high for one cycle, in the cycle right after the `ee_ack` cycle that delivered it.
- R9: While `ee_req` is high and `ee_ack` is low, `ee_req`, `ee_addr`, `ee_we` and `ee_wdata` hold their values into the next cycle.
- R10: While busy, every host register write has no effect: no register changes and no new EEPROM operation starts.
- R11: A control write with several request bits set starts only the highest-priority one (burst over read over write) and discards the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Register index: 0 address, 1 data, 2 control, 3 window base |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Read data of the indexed register (combinational) |
| ee_req | output | 1 | EEPROM byte request, held until acknowledged |
| ee_we | output | 1 | 1 = byte write, 0 = byte read |
| ee_addr | output | 16 | EEPROM byte address |
| ee_wdata | output | 8 | Byte to write |
| ee_ack | input | 1 | One-cycle completion from the adapter |
| ee_rdata | input | 8 | Byte read, valid with `ee_ack` |
| mem_we | output | 1 | Memory write strobe for one burst payload byte |
| mem_addr | output | 24 | Memory write address |
| mem_wdata | output | 8 | Memory write data |

## Verification
A control write made at one falling edge takes effect at the next rising edge. So `ee_req`, the first EEPROM address and the busy bit are sampled at the falling edge that ends the write cycle. The request bits clear one edge after the `ee_ack` cycle, and the bench polls the control register at falling edges until they clear before it reads the data register. The memory write is due exactly one cycle after its acknowledge. The bench monitors this at each falling edge against the acknowledge seen at the falling edge before, and compares each captured write in order against addresses and bytes computed from the record image it loaded.

// File: rtl/eel_pkg.sv
`timescale 1ns/1ps
package eel_pkg;
    localparam int BYTE_W = 8;

    // host register indices
    localparam logic [1:0] IDX_ADDR = 2'd0;
    localparam logic [1:0] IDX_DATA = 2'd1;
    localparam logic [1:0] IDX_CTRL = 2'd2;
    localparam logic [1:0] IDX_BASE = 2'd3;

    // control register bit positions
    localparam int CTRL_WR    = 0;
    localparam int CTRL_RD    = 1;
    localparam int CTRL_BURST = 2;

    typedef enum logic [1:0] {OP_NONE, OP_WR, OP_RD, OP_BURST} op_e;
    typedef enum logic [1:0] {ST_IDLE, ST_SINGLE, ST_BURST} seq_st_e;
    typedef enum logic [1:0] {PH_AHI, PH_ALO, PH_LEN, PH_DAT} phase_e;

    typedef struct packed {
        logic busy;
        logic burst_pend;
        logic rd_pend;
        logic wr_pend;
    } status_t;

    // burst outranks read, read outranks write
    function automatic op_e pick_op(input logic [2:0] bits);
        if (bits[CTRL_BURST])   return OP_BURST;
        else if (bits[CTRL_RD]) return OP_RD;
        else if (bits[CTRL_WR]) return OP_WR;
        else                    return OP_NONE;
    endfunction
endpackage

// File: rtl/eel_hostregs.sv
`timescale 1ns/1ps
module eel_hostregs
    import eel_pkg::*;
#(
    parameter int EE_AW  = 16,
    parameter int BASE_W = 9,
    parameter int REG_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  status_t              st,
    input  logic                 rd_done,
    input  logic [BYTE_W-1:0]    rd_byte,
    output logic [EE_AW-1:0]     addr_q,
    output logic [BYTE_W-1:0]    data_q,
    output logic [BASE_W-1:0]    base_q,
    output op_e                  launch
);
    logic wr_ok;
    assign wr_ok = reg_wr && !st.busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            base_q <= '0;
        end else begin
            if (wr_ok) begin
                case (reg_addr)
                    IDX_ADDR: addr_q <= reg_wdata[EE_AW-1:0];
                    IDX_DATA: data_q <= reg_wdata[BYTE_W-1:0];
                    IDX_BASE: base_q <= reg_wdata[BASE_W-1:0];
                    default:  ;
                endcase
            end
            if (rd_done) data_q <= rd_byte;
        end
    end

    assign launch = (wr_ok && reg_addr == IDX_CTRL) ? pick_op(reg_wdata[2:0]) : OP_NONE;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            IDX_ADDR: reg_rdata[EE_AW-1:0]  = addr_q;
            IDX_DATA: reg_rdata[BYTE_W-1:0] = data_q;
            IDX_CTRL: reg_rdata[3:0]        = st;
            IDX_BASE: reg_rdata[BASE_W-1:0] = base_q;
            default:  ;
        endcase
    end

    // R10
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && st.busy) |=> ($stable(addr_q) && $stable(base_q)));
endmodule

// File: rtl/eel_seq.sv
`timescale 1ns/1ps
module eel_seq
    import eel_pkg::*;
#(
    parameter int EE_AW  = 16,
    parameter int TGT_AW = 24,
    parameter int OFF_W  = 15   // must lie between BYTE_W+1 and 2*BYTE_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  op_e                     launch,
    input  logic [EE_AW-1:0]        addr_q,
    input  logic [BYTE_W-1:0]       data_q,
    input  logic [TGT_AW-OFF_W-1:0] base_q,
    output logic                    ee_req,
    output logic                    ee_we,
    output logic [EE_AW-1:0]        ee_addr,
    output logic [BYTE_W-1:0]       ee_wdata,
    input  logic                    ee_ack,
    input  logic [BYTE_W-1:0]       ee_rdata,
    output logic                    mem_we,
    output logic [TGT_AW-1:0]       mem_addr,
    output logic [BYTE_W-1:0]       mem_wdata,
    output status_t                 st,
    output logic                    rd_done,
    output logic [BYTE_W-1:0]       rd_byte
);
    localparam int HI_W = OFF_W - BYTE_W;

    seq_st_e            st_q;
    phase_e             phase_q;
    logic               single_we_q;
    logic [EE_AW-1:0]   cursor_q;   // next address a burst fetches
    logic [OFF_W-1:0]   off_q;
    logic [BYTE_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            phase_q     <= PH_AHI;
            single_we_q <= 1'b0;
            cursor_q    <= '0;
            off_q       <= '0;
            cnt_q       <= '0;
            mem_we      <= 1'b0;
            mem_addr    <= '0;
            mem_wdata   <= '0;
        end else begin
            mem_we <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    case (launch)
                        OP_WR:    begin st_q <= ST_SINGLE; single_we_q <= 1'b1; end
                        OP_RD:    begin st_q <= ST_SINGLE; single_we_q <= 1'b0; end
                        OP_BURST: begin st_q <= ST_BURST;  phase_q <= PH_AHI; end
                        default:  ;
                    endcase
                end
                ST_SINGLE: begin
                    if (ee_ack) begin
                        st_q     <= ST_IDLE;
                        cursor_q <= addr_q + EE_AW'(1);
                    end
                end
                ST_BURST: begin
                    if (ee_ack) begin
                        cursor_q <= cursor_q + EE_AW'(1);
                        case (phase_q)
                            PH_AHI: begin
                                off_q[OFF_W-1:BYTE_W] <= ee_rdata[HI_W-1:0];
                                phase_q <= PH_ALO;
                            end
                            PH_ALO: begin
                                off_q[BYTE_W-1:0] <= ee_rdata;
                                phase_q <= PH_LEN;
                            end
                            PH_LEN: begin
                                if (ee_rdata == '0) begin
                                    st_q    <= ST_IDLE;
                                    phase_q <= PH_AHI;
                                end else begin
                                    cnt_q   <= ee_rdata;
                                    phase_q <= PH_DAT;
                                end
                            end
                            PH_DAT: begin
                                mem_we    <= 1'b1;
                                mem_addr  <= {base_q, off_q};
                                mem_wdata <= ee_rdata;
                                off_q     <= off_q + OFF_W'(1);
                                cnt_q     <= cnt_q - BYTE_W'(1);
                                if (cnt_q == BYTE_W'(1)) phase_q <= PH_AHI;
                            end
                            default: ;
                        endcase
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign ee_req   = (st_q != ST_IDLE);
    assign ee_we    = (st_q == ST_SINGLE) && single_we_q;
    assign ee_addr  = (st_q == ST_BURST) ? cursor_q : addr_q;
    assign ee_wdata = data_q;

    assign rd_done  = (st_q == ST_SINGLE) && !single_we_q && ee_ack;
    assign rd_byte  = ee_rdata;

    assign st.busy       = (st_q != ST_IDLE);
    assign st.burst_pend = (st_q == ST_BURST);
    assign st.rd_pend    = (st_q == ST_SINGLE) && !single_we_q;
    assign st.wr_pend    = (st_q == ST_SINGLE) && single_we_q;

    // R9
    ee_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ee_req && !ee_ack) |=> (ee_req && $stable(ee_addr) && $stable(ee_we) && $stable(ee_wdata)));

    // R8
    mem_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($past(ee_ack) && $past(st_q == ST_BURST)));

    // R4
    launch_starts_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && launch != OP_NONE) |=> ee_req);
endmodule

// File: rtl/eeprom_burst_loader.sv
`timescale 1ns/1ps
module eeprom_burst_loader
    import eel_pkg::*;
#(
    parameter int EE_AW  = 16,
    parameter int TGT_AW = 24,
    parameter int OFF_W  = 15,
    parameter int REG_W  = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    output logic                ee_req,
    output logic                ee_we,
    output logic [EE_AW-1:0]    ee_addr,
    output logic [7:0]          ee_wdata,
    input  logic                ee_ack,
    input  logic [7:0]          ee_rdata,
    output logic                mem_we,
    output logic [TGT_AW-1:0]   mem_addr,
    output logic [7:0]          mem_wdata
);
    localparam int BASE_W = TGT_AW - OFF_W;

    status_t             st;
    op_e                 launch;
    logic                rd_done;
    logic [BYTE_W-1:0]   rd_byte;
    logic [EE_AW-1:0]    addr_q;
    logic [BYTE_W-1:0]   data_q;
    logic [BASE_W-1:0]   base_q;

    eel_hostregs #(.EE_AW(EE_AW), .BASE_W(BASE_W), .REG_W(REG_W)) regs_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .st(st),
        .rd_done(rd_done), .rd_byte(rd_byte), .addr_q(addr_q),
        .data_q(data_q), .base_q(base_q), .launch(launch)
    );

    eel_seq #(.EE_AW(EE_AW), .TGT_AW(TGT_AW), .OFF_W(OFF_W)) seq_i (
        .clk(clk), .rst(rst), .launch(launch), .addr_q(addr_q),
        .data_q(data_q), .base_q(base_q), .ee_req(ee_req), .ee_we(ee_we),
        .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_ack(ee_ack),
        .ee_rdata(ee_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .st(st), .rd_done(rd_done), .rd_byte(rd_byte)
    );
endmodule

// File: tb/eeprom_burst_loader_tb_top.sv
`timescale 1ns/1ps
module eeprom_burst_loader_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        ee_req, ee_we;
    logic [15:0] ee_addr;
    logic [7:0]  ee_wdata;
    logic        ee_ack = 1'b0;
    logic [7:0]  ee_rdata = '0;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;

    always #2.5 clk = ~clk;

    eeprom_burst_loader dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ee_req(ee_req),
        .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
        .ee_ack(ee_ack), .ee_rdata(ee_rdata), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // EEPROM device model
    logic [7:0] emem [0:1023];
    int lat = 1;
    int wcnt = 0;
    int ee_wr_cnt = 0;
    always @(posedge clk) begin
        ee_ack <= 1'b0;
        if (rst) wcnt <= 0;
        else if (ee_req && !ee_ack) begin
            if (wcnt >= lat) begin
                ee_ack <= 1'b1;
                wcnt <= 0;
                if (ee_we) begin
                    emem[ee_addr[9:0]] <= ee_wdata;
                    ee_wr_cnt <= ee_wr_cnt + 1;
                end else ee_rdata <= emem[ee_addr[9:0]];
            end else wcnt <= wcnt + 1;
        end
    end

    // memory write capture and timing monitor (falling edge)
    logic [23:0] cap_addr [0:63];
    logic [7:0]  cap_data [0:63];
    int cap_n = 0;
    int late_n = 0;
    logic ack_prev = 1'b0;
    always @(negedge clk) begin
        if (mem_we) begin
            if (!ack_prev) late_n++;
            if (cap_n < 64) begin
                cap_addr[cap_n] = mem_addr;
                cap_data[cap_n] = mem_wdata;
            end
            cap_n++;
        end
        ack_prev = ee_ack;
    end

    // expected burst writes
    logic [23:0] exp_addr [0:63];
    logic [7:0]  exp_data [0:63];
    int exp_n = 0;
    int img_pos = 0;
    logic [8:0] base_cur = '0;

    function automatic logic [23:0] tgt(input logic [8:0] b, input logic [14:0] o);
        return {b, o};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] idx, input logic [15:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = idx; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] idx, output logic [15:0] val);
        @(negedge clk);
        reg_addr = idx;
        #1 val = reg_rdata;
    endtask

    task automatic wait_idle(output logic [15:0] ctrl);
        for (int i = 0; i < 3000; i++) begin
            reg_read(2'd2, ctrl);
            if (!ctrl[3]) break;
        end
    endtask

    task automatic add_rec(input logic [15:0] a16, input int len);
        logic [14:0] off;
        emem[img_pos] = a16[15:8];
        emem[img_pos+1] = a16[7:0];
        emem[img_pos+2] = 8'(len);
        img_pos += 3;
        off = a16[14:0];
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            emem[img_pos] = b;
            img_pos++;
            exp_addr[exp_n] = tgt(base_cur, off);
            exp_data[exp_n] = b;
            exp_n++;
            off = off + 15'd1;
        end
    endtask

    task automatic launch_burst(input int start);
        cap_n = 0; late_n = 0;
        reg_write(2'd2, 16'h0004);
        check(ee_req === 1'b1 && !ee_we, "R4 burst request raised", ee_req, 1);
        check(ee_addr == 16'(start), "R5 burst start address", ee_addr, start);
    endtask

    task automatic finish_burst(input string tag);
        logic [15:0] c;
        wait_idle(c);
        check(c[3:0] == 4'h0, "R4 burst bit cleared", c, 0);
        check(cap_n == exp_n, {tag, " R6 write count"}, cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            check(cap_addr[i] == exp_addr[i], {tag, " R7 mem address"}, cap_addr[i], exp_addr[i]);
            check(cap_data[i] == exp_data[i], {tag, " R6 mem data"}, cap_data[i], exp_data[i]);
        end
        check(late_n == 0, {tag, " R8 write timing"}, late_n, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, c;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 1024; i++) emem[i] = 8'($urandom);
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        for (int i = 0; i < 4; i++) begin
            reg_read(2'(i), v);
            check(v == 16'h0, "R1 register reset value", v, 0);
        end
        check(ee_req === 1'b0 && mem_we === 1'b0, "R1 ports idle", {ee_req, mem_we}, 0);

        // first burst after reset: starts at 0, offset top bit ignored, offset wraps
        base_cur = 9'h1A5;
        reg_write(2'd3, 16'h01A5);
        img_pos = 0; exp_n = 0;
        add_rec(16'h8123, 3);
        add_rec(16'h7FFE, 3);
        add_rec(16'h0000, 0);
        lat = 1;
        launch_burst(0);
        reg_read(2'd2, c);
        check(c[3] && c[2], "R4 busy and burst bits during burst", c, 12);
        finish_burst("burst A");

        // second burst continues after the first one
        base_cur = 9'h003;
        reg_write(2'd3, 16'h0003);
        exp_n = 0;
        add_rec(16'h0010, 2);
        add_rec(16'h0000, 0);
        lat = 0;
        launch_burst(15);
        finish_burst("burst B");

        // random single reads and writes
        for (int k = 0; k < 24; k++) begin
            logic [15:0] a;
            logic [7:0] d;
            a = 16'($urandom_range(100, 900));
            d = 8'($urandom);
            lat = $urandom_range(0, 3);
            reg_write(2'd0, a);
            if ($urandom_range(0, 1) == 1) begin
                reg_write(2'd1, {8'h00, d});
                reg_write(2'd2, 16'h0001);
                check(ee_req && ee_we && ee_addr == a && ee_wdata == d, "R3 write request", ee_addr, a);
                wait_idle(c);
                check(c[0] == 1'b0, "R3 write bit cleared", c, 0);
                check(emem[a[9:0]] == d, "R3 byte stored", emem[a[9:0]], d);
            end else begin
                reg_write(2'd2, 16'h0002);
                reg_read(2'd2, c);
                check(c[1] == 1'b1 || !c[3], "R2 read bit pending", c, 2);
                wait_idle(c);
                check(c[1] == 1'b0, "R2 read bit cleared", c, 0);
                reg_read(2'd1, v);
                check(v == {8'h00, emem[a[9:0]]}, "R2 read data", v, emem[a[9:0]]);
            end
        end

        // priority: read and write both requested, only read runs
        emem[600] = 8'h33;
        reg_write(2'd0, 16'd600);
        reg_write(2'd1, 16'h005A);
        begin
            int wr0;
            wr0 = ee_wr_cnt;
            reg_write(2'd2, 16'h0003);
            wait_idle(c);
            reg_read(2'd1, v);
            check(v == 16'h0033, "R11 read wins over write", v, 16'h33);
            check(ee_wr_cnt == wr0 && emem[600] == 8'h33, "R11 write discarded", ee_wr_cnt, wr0);
        end

        // burst after a single access starts at 601; writes while busy ignored
        base_cur = 9'h0F0;
        reg_write(2'd3, 16'h00F0);
        img_pos = 601; exp_n = 0;
        add_rec(16'h00F0, 4);
        add_rec(16'h0000, 0);
        lat = 2;
        begin
            int wr0;
            wr0 = ee_wr_cnt;
            launch_burst(601);
            reg_write(2'd0, 16'h0123);
            reg_write(2'd3, 16'h01FF);
            reg_write(2'd1, 16'h0077);
            reg_write(2'd2, 16'h0001);
            finish_burst("burst C");
            reg_read(2'd0, v);
            check(v == 16'd600, "R10 address unchanged", v, 600);
            reg_read(2'd3, v);
            check(v == 16'h00F0, "R10 base unchanged", v, 16'hF0);
            reg_read(2'd1, v);
            check(v == 16'h0033, "R10 data unchanged", v, 16'h33);
            check(ee_wr_cnt == wr0, "R10 no write started", ee_wr_cnt, wr0);
        end

        // burst whose first record is the terminator
        img_pos = 611; exp_n = 0;
        add_rec(16'h1234, 0);
        lat = 1;
        launch_burst(611);
        finish_burst("burst D");
        img_pos = 614; exp_n = 0;
        add_rec(16'h0002, 1);
        add_rec(16'h0000, 0);
        launch_burst(614);
        finish_burst("burst E");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule